// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block sits between a USB controller core and the CPU's interrupt input. It latches three groups of event pulses into status words: sixteen transmit-endpoint events, sixteen receive-endpoint events and nine core events. It gates each status bit with an enable bit and drives a single level interrupt line. Software changes the enable masks only through dedicated set and clear words, so it never needs a read-modify-write. It acknowledges events by writing ones to the status words.

Once the line has gone high, the wrapper disarms itself. The line can rise again only after software writes the end-of-interrupt word. This lets the handler sweep all status bits without getting a second edge during the sweep. A small 32-bit register port also provides the following:

- a nonzero revision constant;
- a control word whose reset bit clears itself;
- a status word that mirrors the VBUS-drive indication;
- a PHY control word holding the OTG-disable bit;
- a mode word that reports the ID pin.

Top module: `usb_irq_wrap`

## Requirements
- R1: Address 0x00 reads a nonzero constant revision value, and writes to it have no effect.
- R2: An event pulse sets its status bit one cycle later, and the bit stays set until software clears it. Transmit endpoint n maps to bit n of the endpoint status word at 0x30. Receive endpoint n maps to bit 16+n of that word. Core event n maps to bit n of the core status word at 0x34.
- R3: Bit 16 of the endpoint status and enable words (receive endpoint 0) is never set and always reads 0.
- R4: Writing a word to 0x30 or 0x34 clears the status bits that are one in that word. An event arriving in the same cycle as such a write keeps its bit set.
- R5: Writing ones to 0x38 (endpoint) or 0x3C (core) sets those enable bits. Writing ones to 0x40 (endpoint) or 0x44 (core) clears them. Reading either the set address or the clear address of a group returns that group's current enable mask.
- R6: When the wrapper is armed and some status bit has its enable bit set, irq_o goes high one cycle later. irq_o stays high while any enabled status bit remains set, and falls one cycle after the last one is cleared.
- R7: The wrapper disarms when irq_o rises. irq_o cannot rise again until a write to 0x24 re-arms it.
- R8: Writing 1 to bit 0 of 0x14 raises core_rst_o for the following cycle only. Bit 0 of 0x14 reads the current core_rst_o value.
- R9: Bit 21 of 0x E0 is the OTG-disable bit. It resets to 1, can be written, drives otg_dis_o, and reads back in bit 21.
- R10: Address 0x18 reads vbus_drv_i in bit 0. Address 0xE8 reads id_i in bit 8. All other bits of both words read 0.
- R11: After reset, all status and enable bits are 0, the wrapper is armed, irq_o is low and core_rst_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_evt_i | input | 16 | Transmit endpoint event pulses |
| rx_evt_i | input | 16 | Receive endpoint event pulses (bit 0 unused) |
| core_evt_i | input | 9 | Core event pulses; bit 8 is VBUS-drive change |
| vbus_drv_i | input | 1 | VBUS-drive level from the core |
| id_i | input | 1 | ID pin level |
| bus_addr_i | input | 8 | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Level interrupt to the CPU |
| core_rst_o | output | 1 | One-cycle reset pulse to the USB core |
| otg_dis_o | output | 1 | OTG-disable control to the PHY |

## Verification
The bench aims at an event landing in the same cycle as a write-one-to-clear on its own bit. A design that lets the clear win would drop the event and leave the handler unaware of it. The bench also raises new events while the wrapper is disarmed, with no end-of-interrupt write. A design that re-arms on its own would pulse irq_o during the handler's sweep, and one that never re-arms would stay silent after the end-of-interrupt write. The bench tries to set the unimplemented receive-endpoint-0 bit through both the status and the enable paths, and it checks that reads of the clear addresses still return the mask.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned REG_AW      = 8;
  localparam int unsigned DW          = 32;
  localparam int unsigned EP_N        = 16;
  localparam int unsigned CORE_N      = 9;
  localparam int unsigned OTG_DIS_BIT = 21;
  localparam int unsigned ID_BIT      = 8;

  localparam logic [REG_AW-1:0] A_REV      = 8'h00;
  localparam logic [REG_AW-1:0] A_CTL      = 8'h14;
  localparam logic [REG_AW-1:0] A_STAT     = 8'h18;
  localparam logic [REG_AW-1:0] A_EOI      = 8'h24;
  localparam logic [REG_AW-1:0] A_EP_STS   = 8'h30;
  localparam logic [REG_AW-1:0] A_CORE_STS = 8'h34;
  localparam logic [REG_AW-1:0] A_EP_SET   = 8'h38;
  localparam logic [REG_AW-1:0] A_CORE_SET = 8'h3C;
  localparam logic [REG_AW-1:0] A_EP_CLR   = 8'h40;
  localparam logic [REG_AW-1:0] A_CORE_CLR = 8'h44;
  localparam logic [REG_AW-1:0] A_PHY      = 8'hE0;
  localparam logic [REG_AW-1:0] A_MODE     = 8'hE8;

  // receive endpoint 0 does not exist: bit EP_N stays unimplemented
  localparam logic [2*EP_N-1:0] EP_IMPL = ~((2*EP_N)'(1) << EP_N);

  function automatic logic [2*EP_N-1:0] ep_word(input logic [EP_N-1:0] tx,
                                                input logic [EP_N-1:0] rx);
    return {rx, tx} & EP_IMPL;
  endfunction

  function automatic logic [DW-1:0] bit_at(input logic v, input int unsigned pos);
    return DW'(v) << pos;
  endfunction
endpackage

// File: rtl/usb_evt_bank.sv
module usb_evt_bank #(
  parameter int unsigned W    = 9,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] wdata_i,
  input  logic         sts_clr_i,
  input  logic         en_set_i,
  input  logic         en_clr_i,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] en_o,
  output logic         hit_o
);
  logic [W-1:0] sts_q, en_q, clr_mask;

  assign clr_mask = sts_clr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      // new events win over a simultaneous clear
      sts_q <= ((sts_q & ~clr_mask) | evt_i) & IMPL;
      if (en_set_i)      en_q <= (en_q | wdata_i) & IMPL;
      else if (en_clr_i) en_q <= en_q & ~wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign hit_o = |(sts_q & en_q);
endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic eoi_i,
  output logic irq_o,
  output logic armed_o
);
  logic armed_q, irq_q, fire;

  assign fire = armed_q & pend_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      if (eoi_i)     armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
      if (fire)         irq_q <= 1'b1;
      else if (!pend_i) irq_q <= 1'b0;
    end
  end

  assign irq_o   = irq_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
  import usb_irq_pkg::*;
#(
  parameter logic [31:0] REV_ID = 32'h5542_0107
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] tx_evt_i,
  input  logic [15:0] rx_evt_i,
  input  logic [8:0]  core_evt_i,
  input  logic        vbus_drv_i,
  input  logic        id_i,
  input  logic [7:0]  bus_addr_i,
  input  logic        bus_we_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o,
  output logic        core_rst_o,
  output logic        otg_dis_o
);
  localparam int unsigned EPW = 2 * EP_N;

  logic            wr_ctl, eoi_wr, ep_clr_wr;
  logic [EPW-1:0]  ep_evt, ep_sts, ep_en;
  logic [CORE_N-1:0] core_sts, core_en;
  logic            ep_hit, core_hit, pending, armed;
  logic            rst_q, otg_q;

  assign wr_ctl    = bus_we_i && (bus_addr_i == A_CTL);
  assign eoi_wr    = bus_we_i && (bus_addr_i == A_EOI);
  assign ep_clr_wr = bus_we_i && (bus_addr_i == A_EP_CLR);
  assign ep_evt    = ep_word(tx_evt_i, rx_evt_i);

  usb_evt_bank #(.W(EPW), .IMPL(EP_IMPL)) u_ep (
    .clk(clk), .rst_n(rst_n), .evt_i(ep_evt), .wdata_i(bus_wdata_i[EPW-1:0]),
    .sts_clr_i(bus_we_i && (bus_addr_i == A_EP_STS)),
    .en_set_i(bus_we_i && (bus_addr_i == A_EP_SET)),
    .en_clr_i(ep_clr_wr),
    .sts_o(ep_sts), .en_o(ep_en), .hit_o(ep_hit)
  );

  usb_evt_bank #(.W(CORE_N), .IMPL('1)) u_core (
    .clk(clk), .rst_n(rst_n), .evt_i(core_evt_i), .wdata_i(bus_wdata_i[CORE_N-1:0]),
    .sts_clr_i(bus_we_i && (bus_addr_i == A_CORE_STS)),
    .en_set_i(bus_we_i && (bus_addr_i == A_CORE_SET)),
    .en_clr_i(bus_we_i && (bus_addr_i == A_CORE_CLR)),
    .sts_o(core_sts), .en_o(core_en), .hit_o(core_hit)
  );

  assign pending = ep_hit | core_hit;

  usb_irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .pend_i(pending), .eoi_i(eoi_wr),
    .irq_o(irq_o), .armed_o(armed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      otg_q <= 1'b1;
    end else begin
      rst_q <= wr_ctl & bus_wdata_i[0];
      if (bus_we_i && (bus_addr_i == A_PHY)) otg_q <= bus_wdata_i[OTG_DIS_BIT];
    end
  end

  assign core_rst_o = rst_q;
  assign otg_dis_o  = otg_q;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_REV:                  bus_rdata_o = REV_ID;
      A_CTL:                  bus_rdata_o = bit_at(rst_q, 0);
      A_STAT:                 bus_rdata_o = bit_at(vbus_drv_i, 0);
      A_EP_STS:               bus_rdata_o = DW'(ep_sts);
      A_CORE_STS:             bus_rdata_o = DW'(core_sts);
      A_EP_SET, A_EP_CLR:     bus_rdata_o = DW'(ep_en);
      A_CORE_SET, A_CORE_CLR: bus_rdata_o = DW'(core_en);
      A_PHY:                  bus_rdata_o = bit_at(otg_q, OTG_DIS_BIT);
      A_MODE:                 bus_rdata_o = bit_at(id_i, ID_BIT);
      default:                bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/usb_irq_wrap_chk.sv
module usb_irq_wrap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        armed,
  input logic        pending,
  input logic        irq_o,
  input logic        eoi_wr,
  input logic        wr_ctl,
  input logic        core_rst_o,
  input logic        ep_clr_wr,
  input logic [31:0] ep_evt,
  input logic [31:0] ep_sts,
  input logic [31:0] ep_en,
  input logic [31:0] bus_wdata_i
);
  // R6
  fire_to_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && pending |=> irq_o);

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !pending |=> !irq_o);

  // R7
  rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(armed));

  // R7
  stay_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !eoi_wr |=> !armed);

  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_evt != 32'h0 |=> (ep_sts & $past(ep_evt)) == $past(ep_evt));

  // R5
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_clr_wr |=> (ep_en & $past(bus_wdata_i)) == 32'h0);

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> $past(wr_ctl));
endmodule

bind usb_irq_wrap usb_irq_wrap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .pending(pending), .irq_o(irq_o),
  .eoi_wr(eoi_wr), .wr_ctl(wr_ctl), .core_rst_o(core_rst_o), .ep_clr_wr(ep_clr_wr),
  .ep_evt(ep_evt), .ep_sts(ep_sts), .ep_en(ep_en), .bus_wdata_i(bus_wdata_i)
);

// File: tb/usb_irq_wrap_tb.sv
`timescale 1ns/1ps
module usb_irq_wrap_tb;
  localparam logic [31:0] REV   = 32'h5542_0107;
  localparam logic [31:0] EPMSK = 32'hFFFE_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tx_evt = '0, rx_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        vbus = 1'b0, id = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, core_rst, otg_dis;

  int checks = 0, errors = 0;

  // bench model of the register state
  logic [31:0] m_ep, m_epen;
  logic [8:0]  m_co, m_coen;
  logic        m_armed, m_irq, m_rst, m_otg;

  always #2 clk = ~clk;

  usb_irq_wrap u_dut (
    .clk(clk), .rst_n(rst_n), .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
    .core_evt_i(core_evt), .vbus_drv_i(vbus), .id_i(id), .bus_addr_i(bus_addr),
    .bus_we_i(bus_we), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .core_rst_o(core_rst), .otg_dis_o(otg_dis)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic string tag(input logic [7:0] a);
    case (a)
      8'h00: return "R1 revision";
      8'h14: return "R8 control";
      8'h18: return "R10 vbus status";
      8'h30: return "R2/R3/R4 endpoint status";
      8'h34: return "R2/R4 core status";
      8'h38, 8'h40: return "R5/R3 endpoint enables";
      8'h3C, 8'h44: return "R5 core enables";
      8'hE0: return "R9 phy control";
      8'hE8: return "R10 mode";
      default: return "R1 unmapped";
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return REV;
      8'h14: return {31'b0, m_rst};
      8'h18: return {31'b0, vbus};
      8'h30: return m_ep;
      8'h34: return {23'b0, m_co};
      8'h38, 8'h40: return m_epen;
      8'h3C, 8'h44: return {23'b0, m_coen};
      8'hE0: return {10'b0, m_otg, 21'b0};
      8'hE8: return {23'b0, id, 8'b0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input logic [15:0] tx, input logic [15:0] rx, input logic [8:0] co,
                      input logic we, input logic [7:0] a, input logic [31:0] wd);
    logic pend;
    @(negedge clk);
    tx_evt = tx; rx_evt = rx; core_evt = co;
    bus_we = we; bus_addr = a; bus_wdata = wd;
    vbus = 1'($urandom); id = 1'($urandom);
    #1;
    chk({31'b0, irq}, {31'b0, m_irq}, "R6/R7 irq line");
    chk({31'b0, core_rst}, {31'b0, m_rst}, "R8 core reset pulse");
    chk({31'b0, otg_dis}, {31'b0, m_otg}, "R9 otg disable pin");
    if (!we) chk(bus_rdata, exp_rd(a), tag(a));
    @(posedge clk);
    pend = ((m_ep & m_epen) != 0) || ((m_co & m_coen) != 0);
    m_irq   = (m_armed && pend) ? 1'b1 : (pend ? m_irq : 1'b0);
    m_armed = (we && a == 8'h24) ? 1'b1 : ((m_armed && pend) ? 1'b0 : m_armed);
    m_ep = ((m_ep & ~((we && a == 8'h30) ? wd : 32'h0)) | {rx, tx}) & EPMSK;
    m_co = (m_co & ~((we && a == 8'h34) ? wd[8:0] : 9'h0)) | co;
    if (we && a == 8'h38) m_epen = (m_epen | wd) & EPMSK;
    if (we && a == 8'h40) m_epen = m_epen & ~wd;
    if (we && a == 8'h3C) m_coen = m_coen | wd[8:0];
    if (we && a == 8'h44) m_coen = m_coen & ~wd[8:0];
    m_rst = we && a == 8'h14 && wd[0];
    if (we && a == 8'hE0) m_otg = wd[21];
  endtask

  task automatic rd(input logic [7:0] a);
    step('0, '0, '0, 1'b0, a, '0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step('0, '0, '0, 1'b1, a, d);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] wlist [9];
    logic [7:0] rlist [12];
    wlist = '{8'h24, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h44, 8'h14, 8'hE0};
    rlist = '{8'h00, 8'h14, 8'h18, 8'h24, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h44, 8'hE0, 8'hE8};
    void'($urandom(32'd20240611));
    m_ep = '0; m_epen = '0; m_co = '0; m_coen = '0;
    m_armed = 1'b1; m_irq = 1'b0; m_rst = 1'b0; m_otg = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R11 reset state
    #1;
    chk({31'b0, irq}, 32'h0, "R11 irq after reset");
    chk({31'b0, core_rst}, 32'h0, "R11 core reset after reset");
    for (int i = 0; i < 12; i++) rd(rlist[i]);

    // R1 revision ignores writes
    wr(8'h00, 32'h0); rd(8'h00);
    // R3 unimplemented receive endpoint 0 bit
    wr(8'h38, 32'hFFFF_FFFF); rd(8'h38); rd(8'h40);
    step('0, 16'h0001, '0, 1'b0, 8'h30, '0); rd(8'h30);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h38);
    // R6 / R7: fire, sweep without EOI, new event stays silent, then EOI
    wr(8'h3C, 32'h100);
    step('0, '0, 9'h100, 1'b0, 8'h34, '0);
    rd(8'h34); rd(8'h34);
    wr(8'h34, 32'h100); rd(8'h34); rd(8'h34);
    step('0, '0, 9'h100, 1'b0, 8'h34, '0);
    rd(8'h34); rd(8'h34);
    wr(8'h24, 32'h1); rd(8'h34); rd(8'h34);
    // R4 event in same cycle as its clear
    step('0, '0, 9'h100, 1'b1, 8'h34, 32'h1FF); rd(8'h34);
    wr(8'h34, 32'h1FF); wr(8'h24, 32'h0); rd(8'h34);
    // R8 reset pulse and R9 otg disable
    wr(8'h14, 32'h1); rd(8'h14); rd(8'h14);
    wr(8'hE0, 32'h0); rd(8'hE0); wr(8'hE0, 32'h0020_0000); rd(8'hE0);
    rd(8'h18); rd(8'hE8);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] tx, rx;
      logic [8:0] co;
      tx = 16'($urandom & $urandom & $urandom & $urandom);
      rx = 16'($urandom & $urandom & $urandom & $urandom);
      co = 9'($urandom & $urandom & $urandom);
      if ($urandom % 10 < 4)
        step(tx, rx, co, 1'b1, wlist[$urandom % 9], $urandom);
      else
        step(tx, rx, co, 1'b0, rlist[$urandom % 12], '0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule